// File: doc/BRIEF.md
# Per-Set Recency Ranking and Victim Selection

This block holds the replacement state of a set-associative cache. Each set keeps one small saturating counter per way. A high count means the way was used recently, and a count of zero means it is stale or free. Tags and line data live elsewhere. The only job here is to keep the recency ranking up to date and to name the way that should be overwritten on the next miss.

Each cycle the cache controller presents one set index. It may also raise one or more of three strobes:

- a hit strobe, with the way that hit;
- a fill strobe, meaning a missed line is being written into the way the block is currently offering as victim;
- an invalidate strobe, with the way being dropped.

The victim output is combinational from the stored counters of the addressed set, so the controller reads it in the same cycle it raises the fill strobe. A hit and a fill age the other ways by different rules. A hit lowers only the ways ranked above the hit way. A fill lowers every way that is not already at zero.

Top module: `lru_rank_tracker`

## Requirements
- R1: After reset every counter of every set is 0, so `victim_way` reads 0 for every set index.
- R2: `victim_way` names the way of the addressed set with the smallest counter; among equal smallest counters the lowest way index wins.
- R3: On a hit, every other way of that set whose counter is strictly greater than the hit way's counter drops by one, other ways keep their value, and the hit way is loaded with the maximum USAGE_STATES-1.
- R4: On a fill, the way shown on `victim_way` in that same cycle is loaded with USAGE_STATES-1 and every other way of the set with a nonzero counter drops by one.
- R5: On an invalidate, the given way's counter becomes 0 and the other ways of the set keep their values, so that way becomes the victim unless a lower-indexed way is also at 0.
- R6: When several strobes are raised in one cycle, invalidate wins over fill and fill wins over hit; the losing strobes have no effect.
- R7: Counters of sets other than the addressed one never change.
- R8: A counter never goes below 0 and never exceeds USAGE_STATES-1; a zero counter either stays 0 or is loaded with the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| set_idx | input | $clog2(NUM_SETS) | Set addressed this cycle |
| hit_vld | input | 1 | A lookup hit in `hit_way` |
| hit_way | input | $clog2(NUM_WAYS) | Way that hit |
| fill_vld | input | 1 | A line is written into the current victim way |
| inv_vld | input | 1 | Invalidate `inv_way` |
| inv_way | input | $clog2(NUM_WAYS) | Way to invalidate |
| victim_way | output | $clog2(NUM_WAYS) | Replacement candidate for the addressed set |

## Verification
The only visible output is the victim of the addressed set, so a corrupted counter shows up only when it changes which way ranks lowest. That may not happen at once: it can stay hidden for several updates and only surface when a later fill or hit moves the faulty way to the bottom of the ranking. Wrong aging rules tend to be hidden because counters saturating at zero bring the two rules back to the same state. For that reason, long mixed sequences of hits, fills and invalidates are compared against a model after every operation. Damage to a neighbouring set shows up the next time that set is read.

// File: rtl/lru_pkg.sv
package lru_pkg;

    // Operation applied to the addressed set in one cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_HIT  = 2'd1,
        OP_FILL = 2'd2,
        OP_INV  = 2'd3
    } lru_op_e;

endpackage

// File: rtl/lru_op_arbiter.sv
module lru_op_arbiter
    import lru_pkg::*;
(
    input  logic    hit_vld,
    input  logic    fill_vld,
    input  logic    inv_vld,
    output lru_op_e op
);

    // Invalidate over fill over hit
    always_comb begin
        op = OP_IDLE;
        if (inv_vld) begin
            op = OP_INV;
        end else if (fill_vld) begin
            op = OP_FILL;
        end else if (hit_vld) begin
            op = OP_HIT;
        end
    end

endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 2,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0][CNT_W-1:0] cnt,
    output logic [WAY_W-1:0]               victim
);

    logic [CNT_W-1:0] best_val;

    // Linear scan; strict compare keeps the lowest index on ties
    always_comb begin
        victim   = '0;
        best_val = cnt[0];
        for (int w = 1; w < NUM_WAYS; w++) begin
            if (cnt[w] < best_val) begin
                best_val = cnt[w];
                victim   = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/lru_set_update.sv
module lru_set_update
    import lru_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 2,
    parameter int CNT_MAX  = 3,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0][CNT_W-1:0] cnt_in,
    input  lru_op_e                        op,
    input  logic [WAY_W-1:0]               hit_way,
    input  logic [WAY_W-1:0]               fill_way,
    input  logic [WAY_W-1:0]               inv_way,
    output logic [NUM_WAYS-1:0][CNT_W-1:0] cnt_out
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

    logic [CNT_W-1:0] hit_ref;

    assign hit_ref = cnt_in[hit_way];

    // Per-way next value
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        always_comb begin
            cnt_out[w] = cnt_in[w];
            unique case (op)
                OP_HIT: begin
                    if (WAY_W'(w) == hit_way) begin
                        cnt_out[w] = TOP;
                    end else if (cnt_in[w] > hit_ref) begin
                        cnt_out[w] = cnt_in[w] - 1'b1;
                    end
                end
                OP_FILL: begin
                    if (WAY_W'(w) == fill_way) begin
                        cnt_out[w] = TOP;
                    end else if (cnt_in[w] != '0) begin
                        cnt_out[w] = cnt_in[w] - 1'b1;
                    end
                end
                OP_INV: begin
                    if (WAY_W'(w) == inv_way) begin
                        cnt_out[w] = '0;
                    end
                end
                default: cnt_out[w] = cnt_in[w];
            endcase
        end
    end

endmodule

// File: rtl/lru_rank_tracker.sv
module lru_rank_tracker
    import lru_pkg::*;
#(
    parameter int NUM_SETS     = 16,
    parameter int NUM_WAYS     = 4,
    parameter int USAGE_STATES = 4,
    localparam int SET_W       = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W       = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             hit_vld,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             fill_vld,
    input  logic             inv_vld,
    input  logic [WAY_W-1:0] inv_way,
    output logic [WAY_W-1:0] victim_way
);

    localparam int               CNT_W   = (USAGE_STATES > 2) ? $clog2(USAGE_STATES) : 1;
    localparam int               CNT_MAX = USAGE_STATES - 1;
    localparam logic [CNT_W-1:0] TOP     = CNT_W'(CNT_MAX);

    typedef logic [NUM_WAYS-1:0][CNT_W-1:0] row_t;

    typedef struct packed {
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][CNT_W-1:0] cnt;
    } state_t;

    state_t  state_d, state_q;
    row_t    row_cur, row_nxt;
    lru_op_e op;

    assign row_cur = state_q.cnt[set_idx];

    lru_op_arbiter u_arb (
        .hit_vld  (hit_vld),
        .fill_vld (fill_vld),
        .inv_vld  (inv_vld),
        .op       (op)
    );

    lru_victim_pick #(
        .NUM_WAYS (NUM_WAYS),
        .CNT_W    (CNT_W)
    ) u_pick (
        .cnt    (row_cur),
        .victim (victim_way)
    );

    lru_set_update #(
        .NUM_WAYS (NUM_WAYS),
        .CNT_W    (CNT_W),
        .CNT_MAX  (CNT_MAX)
    ) u_upd (
        .cnt_in   (row_cur),
        .op       (op),
        .hit_way  (hit_way),
        .fill_way (victim_way),
        .inv_way  (inv_way),
        .cnt_out  (row_nxt)
    );

    always_comb begin
        state_d = state_q;
        if (op != OP_IDLE) begin
            state_d.cnt[set_idx] = row_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- assertions ----------------
    AST_HIT_LOADS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vld && !fill_vld && !inv_vld) |=> (state_q.cnt[$past(set_idx)][$past(hit_way)] == TOP)); // R3

    AST_FILL_LOADS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_vld && !inv_vld) |=> (state_q.cnt[$past(set_idx)][$past(victim_way)] == TOP)); // R4

    AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        inv_vld |=> (state_q.cnt[$past(set_idx)][$past(inv_way)] == '0)); // R5

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_chk_way
        AST_VICTIM_IS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
            (row_cur[victim_way] < row_cur[w]) ||
            ((row_cur[victim_way] == row_cur[w]) && (victim_way <= WAY_W'(w)))); // R2
    end

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_chk_set
        AST_OTHER_SET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (set_idx != SET_W'(s)) |=> $stable(state_q.cnt[s])); // R7
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cw
            AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q.cnt[s][w] == '0) |=>
                    ((state_q.cnt[s][w] == '0) || (state_q.cnt[s][w] == TOP))); // R8
        end
    end

endmodule

// File: tb/lru_rank_tracker_tb_top.sv
module lru_rank_tracker_tb_top;

    localparam int NS   = 16;
    localparam int NW   = 4;
    localparam int US   = 4;
    localparam int MAXC = US - 1;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] set_idx;
    logic       hit_vld;
    logic [1:0] hit_way;
    logic       fill_vld;
    logic       inv_vld;
    logic [1:0] inv_way;
    logic [1:0] victim_way;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int mcnt [NS][NW];
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    lru_rank_tracker #(.NUM_SETS(NS), .NUM_WAYS(NW), .USAGE_STATES(US)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_idx    (set_idx),
        .hit_vld    (hit_vld),
        .hit_way    (hit_way),
        .fill_vld   (fill_vld),
        .inv_vld    (inv_vld),
        .inv_way    (inv_way),
        .victim_way (victim_way)
    );

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic int model_victim(int s);
        int v = 0;
        for (int w = 1; w < NW; w++) if (mcnt[s][w] < mcnt[s][v]) v = w;
        return v;
    endfunction

    // Reference model built from R3..R6
    function automatic void model_apply(int s, bit h, int hw, bit f, bit iv, int iw);
        int ref_c;
        int vw;
        if (iv) begin
            mcnt[s][iw] = 0;
        end else if (f) begin
            vw = model_victim(s);
            for (int w = 0; w < NW; w++) if (w != vw && mcnt[s][w] > 0) mcnt[s][w]--;
            mcnt[s][vw] = MAXC;
        end else if (h) begin
            ref_c = mcnt[s][hw];
            for (int w = 0; w < NW; w++) if (w != hw && mcnt[s][w] > ref_c) mcnt[s][w]--;
            mcnt[s][hw] = MAXC;
        end
    endfunction

    task automatic check_victim(int s, int exp, string req);
        @(negedge clk);
        set_idx = 4'(s);
        #1;
        n_chk++;
        if (int'(victim_way) != exp) begin
            n_fail++;
            $display("FAIL %s set %0d victim actual %0d expected %0d", req, s, victim_way, exp);
        end
    endtask

    task automatic do_op(int s, bit h, int hw, bit f, bit iv, int iw);
        @(negedge clk);
        set_idx  = 4'(s);
        hit_vld  = h;
        hit_way  = 2'(hw);
        fill_vld = f;
        inv_vld  = iv;
        inv_way  = 2'(iw);
        @(negedge clk);
        hit_vld  = 1'b0;
        fill_vld = 1'b0;
        inv_vld  = 1'b0;
        model_apply(s, h, hw, f, iv, iw);
    endtask

    task automatic t_reset();
        for (int s = 0; s < NS; s++) check_victim(s, 0, "R1");
    endtask

    // Fills from reset rotate the victim 1,2,3,0,1 (R4, R8 saturation)
    task automatic t_fill_order();
        int exp_v [5] = '{1, 2, 3, 0, 1};
        for (int k = 0; k < 5; k++) begin
            do_op(2, 0, 0, 1, 0, 0);
            check_victim(2, exp_v[k], "R4");
        end
    endtask

    // Set 2 is now [3,0,1,2]
    task automatic t_hit();
        do_op(2, 1, 3, 0, 0, 0);         // -> [2,0,1,3]
        check_victim(2, 1, "R3");
        do_op(2, 1, 1, 0, 0, 0);         // -> [1,3,0,2]
        check_victim(2, 2, "R3");
        do_op(2, 1, 2, 0, 0, 0);         // -> [0,2,3,1]
        check_victim(2, 0, "R3");
    endtask

    task automatic t_invalidate();
        do_op(2, 0, 0, 1, 0, 0);         // fill w0 -> [3,1,2,0]
        check_victim(2, 3, "R4");
        do_op(2, 0, 0, 0, 1, 2);         // inv w2 -> [3,1,0,0]
        check_victim(2, 2, "R5");
        do_op(2, 0, 0, 0, 1, 0);         // inv w0 -> [0,1,0,0]
        check_victim(2, 0, "R5");
    endtask

    task automatic t_priority();
        do_op(5, 0, 0, 1, 0, 0);
        do_op(5, 0, 0, 1, 0, 0);
        do_op(5, 0, 0, 1, 0, 0);         // [1,2,3,0]
        check_victim(5, 3, "R4");
        do_op(5, 1, 3, 0, 1, 1);         // inv wins -> [1,0,3,0]
        check_victim(5, 1, "R6");
        do_op(5, 1, 0, 1, 0, 0);         // fill wins -> [0,3,2,0]
        check_victim(5, 0, "R6");
        do_op(5, 0, 0, 1, 1, 0);         // inv w0 wins, fill dropped -> [0,3,2,0]
        check_victim(5, 0, "R6");
        do_op(5, 0, 0, 1, 0, 0);         // fill w0 -> [3,2,1,0]
        check_victim(5, 3, "R6");
    endtask

    task automatic t_isolation();
        for (int s = 0; s < NS; s++) check_victim(s, model_victim(s), "R7");
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 600; k++) begin
            int s;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s = int'(lfsr[3:0]) & 3;
            do_op(s, lfsr[4], int'(lfsr[6:5]), lfsr[7] & lfsr[8],
                  lfsr[9] & lfsr[10] & lfsr[11], int'(lfsr[13:12]));
            check_victim(s, model_victim(s), "R2");
        end
        for (int s = 0; s < NS; s++) check_victim(s, model_victim(s), "R8");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) mcnt[s][w] = 0;
        rst_n    = 1'b0;
        set_idx  = '0;
        hit_vld  = 1'b0;
        hit_way  = '0;
        fill_vld = 1'b0;
        inv_vld  = 1'b0;
        inv_way  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_order();
        t_hit();
        t_invalidate();
        t_priority();
        t_isolation();
        t_sweep();
        summary();
    end

endmodule